// File: doc/BRIEF.md
# Memory Controller Read/Write Scheduler

This block sits between a memory controller's pending-command queues and its command issue stage. On every cycle it decides which direction, read or write, the next command comes from. It raises a one-cycle grant when the issue stage can accept a command. The choice is made by a four-state policy machine. Reads normally win. A build-up of writes beyond a high mark hands priority to writes until the backlog drains to a low mark. A moderate backlog with both queues busy makes the grants alternate. A read that has waited too long forces read-only service.

The queues themselves supply their non-empty flags, the write occupancy and one age value per read entry. The three limits (write high mark, write low mark, read age limit) arrive as configuration inputs that are held by a register bank elsewhere. The policy state is brought out for debug. Queue storage, DRAM timing, bank handling and ordering within a queue belong to other blocks.

Top module: `rw_sched`

## Requirements
- R1: After reset the policy state is read-priority and no grant is raised while `iss_rdy` is low.
- R2: `pol_state` shows the policy as 0 = read-priority, 1 = write-priority, 2 = mixed, 3 = starved. It changes only at a clock edge, based on the inputs seen in the cycle before.
- R3: In read-priority, when a read is pending it is granted (`sel_wr` = 0).
- R4: When no read is starved and `wr_cnt` is above `thr_hi`, the next state is write-priority from any state. This holds even when `thr_hi` is not above `thr_lo`.
- R5: Write-priority is kept while `wr_cnt` is above `thr_lo` (or above `thr_hi`). Once `wr_cnt` is at or below `thr_lo` and not above `thr_hi`, the machine goes back to read-priority.
- R6: In write-priority, a pending write is granted (`sel_wr` = 1).
- R7: A read entry is starved when its valid bit is set and its age is above `age_lim`. Entries whose valid bit is clear are ignored. Any starved entry makes the next state starved, and this overrides every other rule. In the starved state only reads are granted. When no entry is starved, the machine leaves to read-priority, or to write-priority if R4 applies.
- R8: The machine moves from read-priority to mixed when both queues are non-empty and `thr_lo` < `wr_cnt` <= `thr_hi`. It leaves mixed for read-priority when either queue is empty or `wr_cnt` <= `thr_lo`.
- R9: In mixed, the preferred direction is the opposite of the most recent grant. After reset, the most recent grant counts as a write.
- R10: Outside the starved state, when the preferred queue is empty and the other one is not, the other queue is granted.
- R11: `grant` is raised only when `iss_rdy` is high and some command can be chosen. At most one grant is raised per cycle. `sel_wr` is 0 whenever `grant` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | Read queue non-empty |
| wr_vld | input | 1 | Write queue non-empty |
| wr_cnt | input | CNT_W | Write queue occupancy |
| rd_age | input | NUM_RD*AGE_W | Per-entry read wait ages, entry i in bits [i*AGE_W +: AGE_W] |
| rd_age_vld | input | NUM_RD | Per-entry read valid bits |
| thr_hi | input | CNT_W | Write high mark |
| thr_lo | input | CNT_W | Write low mark |
| age_lim | input | AGE_W | Read age limit |
| iss_rdy | input | 1 | Issue stage can take a command |
| grant | output | 1 | Command granted this cycle |
| sel_wr | output | 1 | Granted direction, 1 = write |
| pol_state | output | 2 | Current policy state |

## Verification
`grant` and `sel_wr` depend on the inputs of the current cycle combined with the registered policy and last-direction state. They are therefore due in the same cycle as the stimulus. The bench drives inputs on the falling edge and reads the outputs shortly after, before the next rising edge. `pol_state` reflects the inputs one rising edge later. Each table row therefore lists the state that the previous row's inputs should have produced, and the mixed-mode alternation is predicted from the grants of earlier rows.

// File: rtl/rws_pkg.sv
package rws_pkg;

   typedef enum logic [1:0] {
      POL_RD  = 2'd0,
      POL_WR  = 2'd1,
      POL_MIX = 2'd2,
      POL_STV = 2'd3
   } pol_e;

endpackage

// File: rtl/rws_age_scan.sv
module rws_age_scan #(
   parameter int NUM_RD = 8,
   parameter int AGE_W  = 8
) (
   input  logic [NUM_RD*AGE_W-1:0] rd_age,
   input  logic [NUM_RD-1:0]       rd_age_vld,
   input  logic [AGE_W-1:0]        age_lim,
   output logic                    starved
);

   logic [NUM_RD-1:0] over;

   // one comparator per read entry
   for (genvar i = 0; i < NUM_RD; i++) begin : g_ent
      assign over[i] = rd_age_vld[i] && (rd_age[i*AGE_W +: AGE_W] > age_lim);
   end

   assign starved = |over;

endmodule

// File: rtl/rws_policy_fsm.sv
module rws_policy_fsm
   import rws_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             starved,
   input  logic             rd_vld,
   input  logic             wr_vld,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic [CNT_W-1:0] thr_hi,
   input  logic [CNT_W-1:0] thr_lo,
   output pol_e             state
);

   pol_e nxt;
   logic above_hi, above_lo, both_busy;

   assign above_hi  = wr_cnt > thr_hi;
   assign above_lo  = wr_cnt > thr_lo;
   assign both_busy = rd_vld && wr_vld;

   always_comb begin
      nxt = state;
      if (starved) begin
         nxt = POL_STV;
      end else if (above_hi) begin
         nxt = POL_WR;
      end else begin
         unique case (state)
            POL_RD:  nxt = (both_busy && above_lo) ? POL_MIX : POL_RD;
            POL_WR:  nxt = above_lo ? POL_WR : POL_RD;
            POL_MIX: nxt = (both_busy && above_lo) ? POL_MIX : POL_RD;
            POL_STV: nxt = POL_RD;
            default: nxt = POL_RD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= POL_RD;
      else        state <= nxt;
   end

   AST_STARVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      starved |=> state == POL_STV); // R7
   AST_HI_TO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (!starved && above_hi) |=> state == POL_WR); // R4
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == POL_WR && !starved && above_lo) |=> state == POL_WR); // R5
   AST_MIX_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == POL_MIX && !starved && !above_hi && !both_busy) |=> state == POL_RD); // R8

endmodule

// File: rtl/rws_dir_pick.sv
module rws_dir_pick
   import rws_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  pol_e state,
   input  logic rd_vld,
   input  logic wr_vld,
   input  logic iss_rdy,
   output logic grant,
   output logic sel_wr
);

   logic last_wr;   // direction of most recent grant
   logic pref_wr;
   logic dir_wr;
   logic can_go;

   always_comb begin
      unique case (state)
         POL_WR:  pref_wr = 1'b1;
         POL_MIX: pref_wr = !last_wr;
         default: pref_wr = 1'b0;
      endcase
   end

   always_comb begin
      if (state == POL_STV) begin
         dir_wr = 1'b0;
         can_go = rd_vld;
      end else begin
         dir_wr = pref_wr ? wr_vld : !rd_vld;
         can_go = rd_vld || wr_vld;
      end
   end

   assign grant  = iss_rdy && can_go;
   assign sel_wr = grant && dir_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)     last_wr <= 1'b1;
      else if (grant) last_wr <= sel_wr;
   end

   AST_GNT_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (iss_rdy && (rd_vld || wr_vld))); // R11
   AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> !sel_wr); // R11
   AST_STV_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == POL_STV && grant) |-> !sel_wr); // R7
   AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == POL_RD && grant && rd_vld) |-> !sel_wr); // R3
   AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == POL_WR && grant && wr_vld) |-> sel_wr); // R6

endmodule

// File: rtl/rw_sched.sv
module rw_sched
   import rws_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int NUM_RD = 8,
   parameter int AGE_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_vld,
   input  logic                    wr_vld,
   input  logic [CNT_W-1:0]        wr_cnt,
   input  logic [NUM_RD*AGE_W-1:0] rd_age,
   input  logic [NUM_RD-1:0]       rd_age_vld,
   input  logic [CNT_W-1:0]        thr_hi,
   input  logic [CNT_W-1:0]        thr_lo,
   input  logic [AGE_W-1:0]        age_lim,
   input  logic                    iss_rdy,
   output logic                    grant,
   output logic                    sel_wr,
   output logic [1:0]              pol_state
);

   localparam int AGE_BITS = NUM_RD * AGE_W;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("rw_sched: CNT_W must be at least 2");
   end
   if (NUM_RD < 1) begin : g_bad_num
      $error("rw_sched: NUM_RD must be at least 1");
   end
   if (AGE_W < 1 || AGE_BITS > 4096) begin : g_bad_age
      $error("rw_sched: age vector width out of range");
   end

   logic starved;
   pol_e state;

   rws_age_scan #(.NUM_RD(NUM_RD), .AGE_W(AGE_W)) u_scan (
      .rd_age     (rd_age),
      .rd_age_vld (rd_age_vld),
      .age_lim    (age_lim),
      .starved    (starved)
   );

   rws_policy_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .starved (starved),
      .rd_vld  (rd_vld),
      .wr_vld  (wr_vld),
      .wr_cnt  (wr_cnt),
      .thr_hi  (thr_hi),
      .thr_lo  (thr_lo),
      .state   (state)
   );

   rws_dir_pick u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .rd_vld  (rd_vld),
      .wr_vld  (wr_vld),
      .iss_rdy (iss_rdy),
      .grant   (grant),
      .sel_wr  (sel_wr)
   );

   assign pol_state = state;

endmodule

// File: tb/sim_rw_sched.sv
module sim_rw_sched;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 6;
   localparam int NUM_RD = 8;
   localparam int AGE_W  = 8;
   localparam int NVEC   = 22;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    rd_vld = 1'b0, wr_vld = 1'b0, iss_rdy = 1'b0;
   logic [CNT_W-1:0]        wr_cnt = '0;
   logic [NUM_RD*AGE_W-1:0] rd_age = '0;
   logic [NUM_RD-1:0]       rd_age_vld = '1;
   logic [CNT_W-1:0]        thr_hi = 6'd10, thr_lo = 6'd4;
   logic [AGE_W-1:0]        age_lim = 8'd20;
   logic                    grant, sel_wr;
   logic [1:0]              pol_state;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rw_sched #(.CNT_W(CNT_W), .NUM_RD(NUM_RD), .AGE_W(AGE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .wr_vld(wr_vld),
      .wr_cnt(wr_cnt), .rd_age(rd_age), .rd_age_vld(rd_age_vld),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .age_lim(age_lim),
      .iss_rdy(iss_rdy), .grant(grant), .sel_wr(sel_wr), .pol_state(pol_state)
   );

   // {rd_vld, wr_vld, wr_cnt[5:0], old_read, iss_rdy, exp_state[1:0], exp_grant, exp_sel, 2'b00}
   // exp_state is the state produced by the previous row's inputs (hi=10, lo=4, limit=20)
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b1,1'b0,6'd0, 1'b0,1'b1,2'd0,1'b1,1'b0,2'b00}, // 0  R3 read in read-priority
      {1'b0,1'b1,6'd2, 1'b0,1'b1,2'd0,1'b1,1'b1,2'b00}, // 1  R10 write fallback
      {1'b1,1'b1,6'd2, 1'b0,1'b0,2'd0,1'b0,1'b0,2'b00}, // 2  R11 not ready
      {1'b1,1'b1,6'd6, 1'b0,1'b1,2'd0,1'b1,1'b0,2'b00}, // 3  R3, arms R8
      {1'b1,1'b1,6'd6, 1'b0,1'b1,2'd2,1'b1,1'b1,2'b00}, // 4  R8 mixed, R9 write after read
      {1'b1,1'b1,6'd6, 1'b0,1'b1,2'd2,1'b1,1'b0,2'b00}, // 5  R9 read after write
      {1'b1,1'b1,6'd6, 1'b0,1'b0,2'd2,1'b0,1'b0,2'b00}, // 6  R11 stall keeps turn
      {1'b1,1'b1,6'd6, 1'b0,1'b1,2'd2,1'b1,1'b1,2'b00}, // 7  R9 write
      {1'b1,1'b1,6'd11,1'b0,1'b1,2'd2,1'b1,1'b0,2'b00}, // 8  R9 read, arms R4
      {1'b1,1'b1,6'd8, 1'b0,1'b1,2'd1,1'b1,1'b1,2'b00}, // 9  R4 entered, R6 write first
      {1'b1,1'b1,6'd5, 1'b0,1'b1,2'd1,1'b1,1'b1,2'b00}, // 10 R5 hold above low mark
      {1'b1,1'b0,6'd0, 1'b0,1'b1,2'd1,1'b1,1'b0,2'b00}, // 11 R5 hold, R10 read fallback
      {1'b1,1'b1,6'd12,1'b0,1'b1,2'd0,1'b1,1'b0,2'b00}, // 12 R5 released
      {1'b1,1'b1,6'd12,1'b1,1'b1,2'd1,1'b1,1'b1,2'b00}, // 13 R4 direct from read-priority
      {1'b1,1'b1,6'd12,1'b1,1'b1,2'd3,1'b1,1'b0,2'b00}, // 14 R7 starved, reads only
      {1'b1,1'b1,6'd12,1'b0,1'b1,2'd3,1'b1,1'b0,2'b00}, // 15 R7 still starved
      {1'b1,1'b1,6'd3, 1'b1,1'b1,2'd1,1'b1,1'b1,2'b00}, // 16 R7 exit to write via R4
      {1'b1,1'b1,6'd3, 1'b0,1'b1,2'd3,1'b1,1'b0,2'b00}, // 17 R7 starved over write-priority
      {1'b0,1'b0,6'd0, 1'b0,1'b1,2'd0,1'b0,1'b0,2'b00}, // 18 R7 exit to read, R11 idle
      {1'b1,1'b1,6'd6, 1'b0,1'b1,2'd0,1'b1,1'b0,2'b00}, // 19 R3
      {1'b1,1'b0,6'd0, 1'b0,1'b1,2'd2,1'b1,1'b0,2'b00}, // 20 R8 mixed, R10 fallback
      {1'b0,1'b0,6'd0, 1'b0,1'b0,2'd0,1'b0,1'b0,2'b00}  // 21 R8 left mixed
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_old(input logic old);
      rd_age = '0;
      rd_age[3*AGE_W +: AGE_W] = old ? 8'd25 : 8'd5;
   endtask

   task automatic drive(input logic r, input logic w, input int c, input logic rdy);
      rd_vld = r; wr_vld = w; wr_cnt = CNT_W'(c); iss_rdy = rdy;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during and after reset
      drive(1'b1, 1'b0, 0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 state after reset", pol_state, 0);
      chk("R1 no grant without ready", grant, 0);
      drive(1'b0, 1'b0, 0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VEC[i][15], VEC[i][14], int'(VEC[i][13:8]), VEC[i][6]);
         set_old(VEC[i][7]);
         #1;
         chk($sformatf("R2 state row %0d", i), pol_state, int'(VEC[i][5:4]));
         chk($sformatf("R11 grant row %0d", i), grant, int'(VEC[i][3]));
         chk($sformatf("R10 direction row %0d", i), sel_wr, int'(VEC[i][2]));
      end

      // R7: an old age on an entry whose valid bit is clear is ignored
      @(negedge clk);
      drive(1'b1, 1'b0, 0, 1'b1);
      rd_age = '0;
      rd_age[5*AGE_W +: AGE_W] = 8'd99;
      rd_age_vld = 8'b1101_1111;
      @(negedge clk);
      #1;
      chk("R7 invalid entry ignored", pol_state, 0);
      rd_age_vld = '1;
      rd_age = '0;

      // R4 with misconfigured marks: hi=3, lo=8
      thr_hi = 6'd3; thr_lo = 6'd8;
      drive(1'b1, 1'b1, 5, 1'b1);
      @(negedge clk);
      #1;
      chk("R4 misconfigured enters write", pol_state, 1);
      chk("R6 write granted", sel_wr, 1);
      @(negedge clk);
      #1;
      chk("R4 misconfigured holds write", pol_state, 1);
      drive(1'b1, 1'b1, 2, 1'b1);
      @(negedge clk);
      #1;
      chk("R5 release at or below low mark", pol_state, 0);

      // R8: mixed left when write count drops to the low mark
      thr_hi = 6'd10; thr_lo = 6'd4;
      drive(1'b1, 1'b1, 7, 1'b0);
      @(negedge clk);
      #1;
      chk("R8 mixed entered", pol_state, 2);
      drive(1'b1, 1'b1, 4, 1'b0);
      @(negedge clk);
      #1;
      chk("R8 mixed left at low mark", pol_state, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule